// File: doc/BRIEF.md
# Hitless Reference Switch Sequencer

This block steers a clock loop through a disturbance in reference phase, such as the step that follows a change of reference input. It starts out unarmed and arms once the lock detector first reports lock. From then on, a loss-of-lock report starts a sequence. First the phase detector is gated off and the loop is forced to narrow bandwidth. In the build-out option, the block then emits a one-cycle load of a signed slip for the feedback divider. The slip moves the feedback edge onto the nearest oscillator-cycle position to the new reference edge. Next the phase detector is switched back on. The block waits for a run of consecutive tight-lock results, lets a settle timer expire, releases narrow bandwidth and re-arms.

The block has six states. `ST_IDLE` waits for first lock and moves to `ST_ARMED` when the loss-of-lock flag is low. `ST_ARMED` moves to `ST_HOLD` when loss of lock is reported and the option is not "off". `ST_HOLD` gates the detector for one cycle. It then moves to `ST_BUILD` in the build-out option, or straight to `ST_REACQ` in the plain option. `ST_BUILD` issues the divider load and moves to `ST_REACQ`. `ST_REACQ` counts tight-lock results and moves to `ST_SETTLE` when the run is complete. `ST_SETTLE` times out and returns to `ST_ARMED`.

Top module: `hitless_refswitch_seq`

## Requirements
- R1: After reset the block stays unarmed, with `pd_en_o`=1 and `nbw_o`=`nbw_req_i`. It arms only on a clock edge at which `lol_i` is 0. While it is unarmed, `lol_i`=1 has no effect on the outputs.
- R2: When the block is armed, `opt_sel_i`≠00 and `lol_i`=1 at a clock edge, then in the following cycle `pd_en_o`=0 and `nbw_o`=1.
- R3: `opt_sel_i` is decoded as follows. 00 disables the sequence, so `lol_i` is ignored. 01 gates the detector for exactly one cycle and issues no load. With bit 1 set, the detector is gated for two cycles and `load_o`=1 in the second of them.
- R4: `slip_o` is a two's-complement value of CNT_W+1 bits. Let c be the `ref_cnt_i` value sampled at the trigger edge and L be DIV_LEN. The slip is +c when c ≤ L/2 and c−L otherwise, so a tie resolves to +L/2.
- R5: `pd_en_o` returns to 1 in the cycle after the load cycle, or in the cycle after the single gated cycle in option 01.
- R6: In `ST_REACQ`, a cycle with `pd_tick_i`=1 and `tight_i`=1 advances the run count. A tick with `tight_i`=0 clears the count. Cycles without a tick leave the count unchanged. A run of LOCK_RUN (default 8) consecutive tight ticks ends `ST_REACQ`.
- R7: `nbw_o` stays 1 (with `nbw_req_i`=0) for exactly SETTLE_CYC (default 22, about 175 ns at 125 MHz) cycles after the edge that samples the final tight tick. It falls to 0 after that.
- R8: After the release the block is armed again, and a new loss-of-lock report restarts the sequence.
- R9: `lol_i` has no effect during re-acquisition or settling. The detector stays on and the release time does not move.
- R10: `nbw_req_i`=1 forces `nbw_o`=1 in every state.
- R11: Outside the load cycle, `load_o`=0 and `slip_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lol_i | input | 1 | Loss-of-lock flag, 1 = not locked |
| pd_tick_i | input | 1 | One pulse per phase-detector comparison |
| tight_i | input | 1 | Edges within the tight window on this tick |
| ref_cnt_i | input | CNT_W | Feedback divider count at the new reference edge |
| opt_sel_i | input | 2 | 00 off, 01 hitless only, 1x hitless with build-out |
| nbw_req_i | input | 1 | External narrow-bandwidth request |
| pd_en_o | output | 1 | Phase-detector enable |
| nbw_o | output | 1 | Narrow loop bandwidth select |
| load_o | output | 1 | One-cycle feedback divider slip load strobe |
| slip_o | output | CNT_W+1 | Signed feedback slip in oscillator cycles |

## Verification
The slip calculation is swept over every reference count of a 16-step divider. Each value runs through a full build-out sequence, so the sweep covers both signs of slip, the zero case and the half-period tie. Separate runs compare the three option codes by counting the gated cycles and watching for a load pulse. Tight-tick patterns with idle gaps and a broken run show whether the counter resets on a miss or only on a tick. Loss-of-lock pulses injected during re-acquisition and settling, together with the external narrow request, show that the release time and the bandwidth override do not depend on the sequencer state.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_HOLD   = 3'd2,
        ST_BUILD  = 3'd3,
        ST_REACQ  = 3'd4,
        ST_SETTLE = 3'd5
    } hs_state_e;

    localparam logic [1:0] OPT_OFF = 2'b00;
    localparam logic [1:0] OPT_HS  = 2'b01;

    function automatic logic opt_has_build(input logic [1:0] opt);
        return opt[1];
    endfunction
endpackage

// File: rtl/hs_slip_calc.sv
module hs_slip_calc #(
    parameter int DIV_LEN = 16,
    localparam int CNT_W  = $clog2(DIV_LEN)
) (
    input  logic [CNT_W-1:0] ref_cnt,
    output logic [CNT_W:0]   slip
);
    localparam int HALF = DIV_LEN / 2;
    localparam logic [CNT_W:0] LEN_V = (CNT_W+1)'(DIV_LEN);

    logic [CNT_W:0] wide;

    always_comb begin
        wide = {1'b0, ref_cnt};
        if (int'(ref_cnt) <= HALF) slip = wide;
        else                       slip = wide - LEN_V;
    end
endmodule

// File: rtl/hs_run_counter.sv
module hs_run_counter #(
    parameter int RUN_LEN = 8,
    localparam int RW     = $clog2(RUN_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic hit,
    output logic done
);
    localparam logic [RW-1:0] LAST = RW'(RUN_LEN - 1);

    logic [RW-1:0] cnt_q;

    assign done = !clr && tick && hit && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (clr || done)   cnt_q <= '0;
        else if (tick)          cnt_q <= hit ? cnt_q + 1'b1 : '0;
    end
endmodule

// File: rtl/hs_settle_timer.sv
module hs_settle_timer #(
    parameter int CYC = 22,
    localparam int TW = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam logic [TW-1:0] LAST = TW'(CYC - 1);

    logic [TW-1:0] t_q;

    assign expire = run && (t_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                t_q <= '0;
        else if (!run || expire)   t_q <= '0;
        else                       t_q <= t_q + 1'b1;
    end
endmodule

// File: rtl/hitless_refswitch_seq.sv
module hitless_refswitch_seq
    import hs_seq_pkg::*;
#(
    parameter int DIV_LEN    = 16,
    parameter int LOCK_RUN   = 8,
    parameter int SETTLE_CYC = 22,
    localparam int CNT_W     = $clog2(DIV_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lol_i,
    input  logic             pd_tick_i,
    input  logic             tight_i,
    input  logic [CNT_W-1:0] ref_cnt_i,
    input  logic [1:0]       opt_sel_i,
    input  logic             nbw_req_i,
    output logic             pd_en_o,
    output logic             nbw_o,
    output logic             load_o,
    output logic [CNT_W:0]   slip_o
);
    hs_state_e state_q, state_d;
    logic [CNT_W:0] slip_calc, slip_q;
    logic run_done, settle_done, trigger;

    assign trigger = (state_q == ST_ARMED) && lol_i && (opt_sel_i != OPT_OFF);

    hs_slip_calc #(.DIV_LEN(DIV_LEN)) u_slip (
        .ref_cnt (ref_cnt_i),
        .slip    (slip_calc)
    );

    hs_run_counter #(.RUN_LEN(LOCK_RUN)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_REACQ),
        .tick  (pd_tick_i),
        .hit   (tight_i),
        .done  (run_done)
    );

    hs_settle_timer #(.CYC(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_SETTLE),
        .expire (settle_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!lol_i)      state_d = ST_ARMED;
            ST_ARMED:  if (trigger)     state_d = ST_HOLD;
            ST_HOLD:   state_d = opt_has_build(opt_sel_i) ? ST_BUILD : ST_REACQ;
            ST_BUILD:  state_d = ST_REACQ;
            ST_REACQ:  if (run_done)    state_d = ST_SETTLE;
            ST_SETTLE: if (settle_done) state_d = ST_ARMED;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slip_q  <= '0;
        end else begin
            state_q <= state_d;
            if (trigger) slip_q <= slip_calc;
        end
    end

    always_comb begin
        pd_en_o = 1'b1;
        nbw_o   = nbw_req_i;
        load_o  = 1'b0;
        slip_o  = '0;
        unique case (state_q)
            ST_IDLE, ST_ARMED: ;
            ST_HOLD: begin
                pd_en_o = 1'b0;
                nbw_o   = 1'b1;
            end
            ST_BUILD: begin
                pd_en_o = 1'b0;
                nbw_o   = 1'b1;
                load_o  = 1'b1;
                slip_o  = slip_q;
            end
            ST_REACQ, ST_SETTLE: nbw_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/hs_seq_chk.sv
module hs_seq_chk
    import hs_seq_pkg::*;
#(
    parameter int DIV_LEN = 16,
    localparam int CNT_W  = $clog2(DIV_LEN)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           lol_i,
    input logic [1:0]     opt_sel_i,
    input logic           nbw_req_i,
    input logic           pd_en_o,
    input logic           nbw_o,
    input logic           load_o,
    input logic [CNT_W:0] slip_o,
    input hs_state_e      state_q
);
    localparam int HALF = DIV_LEN / 2;

    assert_unarmed_pd_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> pd_en_o);

    assert_trigger_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && lol_i && opt_sel_i != OPT_OFF) |=> (!pd_en_o && nbw_o));

    assert_gate_is_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_en_o |-> nbw_o);

    assert_off_ignores_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && opt_sel_i == OPT_OFF) |=> pd_en_o);

    assert_load_while_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> !pd_en_o);

    assert_slip_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> (int'($signed(slip_o)) > -HALF && int'($signed(slip_o)) <= HALF));

    assert_reenable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (pd_en_o && !load_o));

    assert_lol_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REACQ && lol_i) |=> (state_q == ST_REACQ || state_q == ST_SETTLE));

    assert_ext_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        nbw_req_i |-> nbw_o);

    assert_quiet_slip_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o |-> (slip_o == '0));
endmodule

bind hitless_refswitch_seq hs_seq_chk #(.DIV_LEN(DIV_LEN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lol_i     (lol_i),
    .opt_sel_i (opt_sel_i),
    .nbw_req_i (nbw_req_i),
    .pd_en_o   (pd_en_o),
    .nbw_o     (nbw_o),
    .load_o    (load_o),
    .slip_o    (slip_o),
    .state_q   (state_q)
);

// File: tb/hitless_refswitch_seq_tb_top.sv
module hitless_refswitch_seq_tb_top;
    localparam int L      = 16;
    localparam int RUN    = 8;
    localparam int SETTLE = 22;
    localparam int CW     = $clog2(L);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lol = 1'b1, tick = 1'b0, tight = 1'b0, nreq = 1'b0;
    logic [CW-1:0] rcnt = '0;
    logic [1:0] opt = 2'b10;
    logic pd_en, nbw, load;
    logic [CW:0] slip;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hitless_refswitch_seq #(.DIV_LEN(L), .LOCK_RUN(RUN), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .lol_i(lol), .pd_tick_i(tick), .tight_i(tight),
        .ref_cnt_i(rcnt), .opt_sel_i(opt), .nbw_req_i(nreq),
        .pd_en_o(pd_en), .nbw_o(nbw), .load_o(load), .slip_o(slip)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // ticks: tight run; release expected SETTLE cycles after the final tight tick edge
    task automatic finish_run(input bool_lol_noise);
        for (int i = 0; i < RUN; i++) begin
            tick = 1'b1; tight = 1'b1;
            if (bool_lol_noise && i == 3) lol = 1'b1;
            step();
            lol = 1'b0;
            tick = 1'b0; tight = 1'b0;
            if (i != RUN - 1) step();   // idle gap between ticks
            chk("R9 pd stays on", pd_en, 1);
        end
        for (int k = 1; k < SETTLE; k++) begin
            if (bool_lol_noise && k == 5) lol = 1'b1;
            step();
            lol = 1'b0;
        end
        chk("R7 narrow held to last settle cycle", nbw, 1);
        step();
        chk("R7 narrow released", nbw, 0);
    endtask

    task automatic trigger_seq(input logic [1:0] o, input int c, input bit noise);
        int exp_slip;
        opt = o; rcnt = CW'(c); lol = 1'b1;
        step();
        lol = 1'b0;
        chk("R2 pd gated", pd_en, 0);
        chk("R2 narrow forced", nbw, 1);
        step();
        if (o[1]) begin
            exp_slip = (c <= L/2) ? c : c - L;
            chk("R3 load pulse", load, 1);
            chk("R3 pd still gated", pd_en, 0);
            chk("R4 slip value", int'($signed(slip)), exp_slip);
            step();
        end
        chk("R5 pd re-enabled", pd_en, 1);
        chk("R11 no load", load, 0);
        chk("R11 slip zero", int'(slip), 0);
        finish_run(noise);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset pd", pd_en, 1);
        chk("R1 reset nbw", nbw, 0);
        chk("R11 reset load", load, 0);
        rst_n = 1'b1;
        // unarmed: lol high must do nothing
        repeat (4) step();
        chk("R1 unarmed pd", pd_en, 1);
        chk("R1 unarmed nbw", nbw, 0);
        lol = 1'b0;
        step();
        // R10 external request
        nreq = 1'b1; step();
        chk("R10 forced narrow", nbw, 1);
        nreq = 1'b0; step();
        chk("R10 released", nbw, 0);
        // R3 option off: lol ignored
        opt = 2'b00; lol = 1'b1;
        repeat (3) step();
        chk("R3 off pd", pd_en, 1);
        chk("R3 off nbw", nbw, 0);
        lol = 1'b0; step();
        // R3 hitless only, with R9 noise
        trigger_seq(2'b01, 5, 1'b1);
        // R6 broken run: 5 tight, miss, then full run
        opt = 2'b10; rcnt = 4'd2; lol = 1'b1;
        step(); lol = 1'b0; step(); step();
        chk("R5 pd on before run", pd_en, 1);
        for (int i = 0; i < 5; i++) begin
            tick = 1'b1; tight = 1'b1; step();
            tick = 1'b0; tight = 1'b0; step();
        end
        tick = 1'b1; tight = 1'b0; step();
        tick = 1'b0;
        repeat (3) step();
        chk("R6 still narrow after miss", nbw, 1);
        finish_run(1'b0);
        // R4 sweep, also exercising R8 re-arm each time
        for (int c = 0; c < L; c++) trigger_seq(2'b10, c, 1'b0);
        // option 11 behaves as build-out
        trigger_seq(2'b11, 8, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule